// File: doc/BRIEF.md
# Static-Memory to ISA Bus Bridge

This bridge lets a microcontroller's asynchronous static-memory port reach an 8/16-bit ISA-style bus that drives a PC card socket controller. It runs entirely on the card-side clock, nominally 25 MHz. The host's chip select, read enable and write enable are brought into that clock domain through two-flop synchronizers. Each recognized access becomes one ISA cycle or two. The host's wait line is held active until the ISA side has finished and, for reads, until the returned word sits on the host data pins.

The most significant host address bit picks the ISA address space. When it is low the access becomes a memory cycle, and when it is high it becomes an I/O cycle. The address bits above it are not connected, so each 16 MB space repeats through the rest of the chip-select window. Two flags describe the configuration: the host bus is 16 bits wide, and the card accepts only byte accesses. When both are set, a single host access is split into two byte cycles. The wait line is then kept active long enough to cover both.

A reset sequencer drives the socket controller's reset for a fixed number of card clocks after the block leaves reset. It then ignores chip-select activity for a further guard interval.

Top module: `smc_isa_bridge`

## Requirements
- R1: While `rst_n` is low, `sock_rst` is 1, `hst_wait_n` is 1 and all four ISA strobes are 1 (inactive).
- R2: After `hst_cs_n` falls together with `hst_oe_n` or `hst_we_n` (block ready and idle), `hst_wait_n` goes low 1 to 2 clock periods later.
- R3: Host address bit 24 selects the space: 0 gives a memory strobe and 1 gives an I/O strobe. `isa_addr` carries host address bits 23:0, apart from bit 0 in split cycles (see R7).
- R4: During any ISA cycle exactly one of `isa_memr_n`, `isa_memw_n`, `isa_ior_n`, `isa_iow_n` is low. The write strobes are chosen when `hst_we_n` is low, and the read strobes when `hst_oe_n` is low.
- R5: Each strobe stays low for at least `STB_CYC`+1 clocks (5 by default). It ends at the first rising edge after that minimum at which `isa_rdy` is high.
- R6: `hst_wait_n` stays low for at least 10 clocks for a memory access and 9 for an I/O access. For a split access the minimums are 24 (memory) and 22 (I/O).
- R7: When `cfg_bus16`=1 and `card_8bit`=1, an access runs as two byte cycles: first with `isa_addr[0]`=0, then with `isa_addr[0]`=1. Writes send data bits 7:0 and then 15:8, both on `isa_dout[7:0]` with `isa_dout[15:8]`=0. Reads return the first byte from `isa_din[7:0]` as `hst_rdata[7:0]` and the second as `hst_rdata[15:8]`. Any other flag combination gives a single cycle.
- R8: A single-cycle access drives all 16 bits of host write data on `isa_dout`, and returns all 16 bits of `isa_din` on `hst_rdata`. `isa_dout_en` is 1 during write strobes.
- R9: `hst_wait_n` returns high only after the last strobe has ended, with read data already on `hst_rdata`. `hst_rdata_en` is 1 exactly while `hst_cs_n` and `hst_oe_n` are both low, with no clock delay.
- R10: After `rst_n` rises, `sock_rst` stays 1 for at least `RST_CYC` clocks (13 by default). Chip-select activity in the `GUARD_CYC` clocks (13) after `sock_rst` falls produces no strobe and no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_oe_n | input | 1 | Host read enable, active low |
| hst_we_n | input | 1 | Host write enable, active low |
| hst_addr | input | ISA_AW+1 | Host address; MSB selects the space |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Read data returned to host |
| hst_rdata_en | output | 1 | Host data pin drive enable |
| hst_wait_n | output | 1 | Host wait, active low |
| cfg_bus16 | input | 1 | Host bus configured 16 bits wide |
| card_8bit | input | 1 | Card accepts byte accesses only |
| sock_rst | output | 1 | Socket controller reset, active high |
| isa_addr | output | ISA_AW | ISA address |
| isa_dout | output | DW | ISA write data |
| isa_dout_en | output | 1 | ISA write data drive enable |
| isa_din | input | DW | ISA read data |
| isa_rdy | input | 1 | ISA ready; low extends the strobe |
| isa_memr_n | output | 1 | ISA memory read strobe |
| isa_memw_n | output | 1 | ISA memory write strobe |
| isa_ior_n | output | 1 | ISA I/O read strobe |
| isa_iow_n | output | 1 | ISA I/O write strobe |

## Verification
A wrong cycle-state or phase register shows up within a single ISA cycle: a strobe of the wrong kind, an odd byte address issued first, or a strobe length that does not match the ready delay the card model applied. A miscounted wait interval appears when `hst_wait_n` rises, as a wait window shorter than the mode minimum. A stale capture register appears as a wrong read word in the same access. Errors in the reset sequencer appear either as `sock_rst` released early or as strobes during the guard window, within the first thirty clocks after reset.

// File: rtl/smc_isa_pkg.sv
package smc_isa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WAIT_READY,
    ST_SECOND_BYTE,
    ST_RELEASE
  } bridge_state_e;

  typedef struct packed {
    logic wr;
    logic io;
    logic split;
  } acc_attr_t;

endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/isa_rst_seq.sv
module isa_rst_seq #(
  parameter int RST_CYC   = 13,
  parameter int GUARD_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic sock_rst,
  output logic ready
);

  localparam int TOTAL = RST_CYC + GUARD_CYC;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != CW'(TOTAL));

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sock_rst = (cnt_q < CW'(RST_CYC));
  assign ready    = !cnt_en;

endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
  import smc_isa_pkg::*;
#(
  parameter int ISA_AW        = 24,
  parameter int DW            = 16,
  parameter int STB_CYC       = 4,
  parameter int MEM_ONE_MIN   = 10,
  parameter int IO_ONE_MIN    = 9,
  parameter int MEM_SPLIT_MIN = 24,
  parameter int IO_SPLIT_MIN  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              cs_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic [ISA_AW:0]   haddr,
  input  logic [DW-1:0]     hwdata,
  input  logic              bus16,
  input  logic              card8,
  output logic [DW-1:0]     hrdata,
  output logic              wait_act,
  output logic [ISA_AW-1:0] isa_addr,
  output logic [DW-1:0]     isa_dout,
  output logic              isa_dout_en,
  input  logic [DW-1:0]     isa_din,
  input  logic              isa_rdy,
  output logic              memr_n,
  output logic              memw_n,
  output logic              ior_n,
  output logic              iow_n
);

  localparam int BW      = DW / 2;
  localparam int MAX_ONE = (MEM_ONE_MIN > IO_ONE_MIN) ? MEM_ONE_MIN : IO_ONE_MIN;
  localparam int MAX_SPL = (MEM_SPLIT_MIN > IO_SPLIT_MIN) ? MEM_SPLIT_MIN : IO_SPLIT_MIN;
  localparam int MAX_MIN = (MAX_ONE > MAX_SPL) ? MAX_ONE : MAX_SPL;
  localparam int WC_W    = $clog2(MAX_MIN + 1);
  localparam int SC_W    = $clog2(STB_CYC + 1);

  bridge_state_e     state_q, state_d;
  acc_attr_t         attr_q;
  logic [ISA_AW-1:0] addr_q;
  logic [DW-1:0]     wd_q;
  logic [DW-1:0]     rd_q;
  logic              phase_q, phase_d;
  logic [WC_W-1:0]   wcnt_q, wcnt_d;
  logic [SC_W-1:0]   scnt_q, scnt_d;
  logic [WC_W-1:0]   min_req;
  logic              start;
  logic              strobe_on;
  logic              busy;
  logic              rd_en;
  logic              last_byte;

  assign start = ready && (state_q == ST_IDLE) && !cs_s && (!oe_s || !we_s);

  always_comb begin
    case ({attr_q.split, attr_q.io})
      2'b00:   min_req = WC_W'(MEM_ONE_MIN);
      2'b01:   min_req = WC_W'(IO_ONE_MIN);
      2'b10:   min_req = WC_W'(MEM_SPLIT_MIN);
      default: min_req = WC_W'(IO_SPLIT_MIN);
    endcase
  end

  assign last_byte = !attr_q.split || phase_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:        if (start) state_d = ST_SETUP;
      ST_SETUP:       state_d = ST_STROBE;
      ST_STROBE:      if (scnt_q == SC_W'(STB_CYC - 1)) state_d = ST_WAIT_READY;
      ST_WAIT_READY:  if (isa_rdy) state_d = last_byte ? ST_RELEASE : ST_SECOND_BYTE;
      ST_SECOND_BYTE: state_d = ST_STROBE;
      ST_RELEASE:     if (cs_s && (wcnt_q >= min_req)) state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wcnt_d = wcnt_q;
    if (start)                   wcnt_d = WC_W'(1);
    else if (state_q == ST_IDLE) wcnt_d = '0;
    else if (wcnt_q != '1)       wcnt_d = wcnt_q + 1'b1;
  end

  always_comb begin
    scnt_d = '0;
    if (state_q == ST_STROBE) scnt_d = scnt_q + 1'b1;
  end

  always_comb begin
    phase_d = phase_q;
    if (start) phase_d = 1'b0;
    else if ((state_q == ST_WAIT_READY) && isa_rdy && !last_byte) phase_d = 1'b1;
  end

  assign rd_en = (state_q == ST_WAIT_READY) && isa_rdy && !attr_q.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      scnt_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      scnt_q  <= scnt_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (start) begin
      attr_q.wr    <= !we_s;
      attr_q.io    <= haddr[ISA_AW];
      attr_q.split <= bus16 && card8;
      addr_q       <= haddr[ISA_AW-1:0];
      wd_q         <= hwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      if (!attr_q.split)  rd_q              <= isa_din;
      else if (phase_q)   rd_q[DW-1:BW]     <= isa_din[BW-1:0];
      else                rd_q[BW-1:0]      <= isa_din[BW-1:0];
    end
  end

  assign strobe_on = (state_q == ST_STROBE) || (state_q == ST_WAIT_READY);
  assign busy      = (state_q == ST_SETUP) || strobe_on || (state_q == ST_SECOND_BYTE);
  assign wait_act  = start || busy || ((state_q == ST_RELEASE) && (wcnt_q < min_req));

  assign memr_n = !(strobe_on && !attr_q.io && !attr_q.wr);
  assign memw_n = !(strobe_on && !attr_q.io &&  attr_q.wr);
  assign ior_n  = !(strobe_on &&  attr_q.io && !attr_q.wr);
  assign iow_n  = !(strobe_on &&  attr_q.io &&  attr_q.wr);

  assign isa_addr    = {addr_q[ISA_AW-1:1], attr_q.split ? phase_q : addr_q[0]};
  assign isa_dout    = attr_q.split ? {{BW{1'b0}}, phase_q ? wd_q[DW-1:BW] : wd_q[BW-1:0]} : wd_q;
  assign isa_dout_en = attr_q.wr && busy;
  assign hrdata      = rd_q;

  // checker: independent count of cycles with wait held
  logic [WC_W:0] chk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_q <= '0;
    else if (!wait_act) chk_q <= '0;
    else if (chk_q != '1) chk_q <= chk_q + 1'b1;
  end

  logic any_stb;
  assign any_stb = !(memr_n && memw_n && ior_n && iow_n);

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~memr_n, ~memw_n, ~ior_n, ~iow_n}));

  a_r9_strobe_under_wait: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> wait_act);

  a_r6_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_act) |-> (chk_q >= {1'b0, min_req}));

  a_r5_ready_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !isa_rdy) |=> any_stb);

  a_r7_even_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(any_stb) && attr_q.split && !phase_q) |-> !isa_addr[0]);

endmodule

// File: rtl/smc_isa_bridge.sv
module smc_isa_bridge #(
  parameter int ISA_AW        = 24,
  parameter int DW            = 16,
  parameter int STB_CYC       = 4,
  parameter int MEM_ONE_MIN   = 10,
  parameter int IO_ONE_MIN    = 9,
  parameter int MEM_SPLIT_MIN = 24,
  parameter int IO_SPLIT_MIN  = 22,
  parameter int CLK_NS        = 40,
  parameter int RST_NS        = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_cs_n,
  input  logic              hst_oe_n,
  input  logic              hst_we_n,
  input  logic [ISA_AW:0]   hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              hst_rdata_en,
  output logic              hst_wait_n,
  input  logic              cfg_bus16,
  input  logic              card_8bit,
  output logic              sock_rst,
  output logic [ISA_AW-1:0] isa_addr,
  output logic [DW-1:0]     isa_dout,
  output logic              isa_dout_en,
  input  logic [DW-1:0]     isa_din,
  input  logic              isa_rdy,
  output logic              isa_memr_n,
  output logic              isa_memw_n,
  output logic              isa_ior_n,
  output logic              isa_iow_n
);

  localparam int RST_CYC   = (RST_NS + CLK_NS - 1) / CLK_NS;
  localparam int GUARD_CYC = RST_CYC;

  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  logic [2:0] ctl_s;
  logic       seq_ready;
  logic       wait_act;

  isa_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({hst_cs_n, hst_oe_n, hst_we_n}),
    .q     (ctl_s)
  );

  isa_rst_seq #(.RST_CYC(RST_CYC), .GUARD_CYC(GUARD_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sock_rst (sock_rst),
    .ready    (seq_ready)
  );

  isa_cycle_fsm #(
    .ISA_AW        (ISA_AW),
    .DW            (DW),
    .STB_CYC       (STB_CYC),
    .MEM_ONE_MIN   (MEM_ONE_MIN),
    .IO_ONE_MIN    (IO_ONE_MIN),
    .MEM_SPLIT_MIN (MEM_SPLIT_MIN),
    .IO_SPLIT_MIN  (IO_SPLIT_MIN)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ready       (seq_ready),
    .cs_s        (ctl_s[2]),
    .oe_s        (ctl_s[1]),
    .we_s        (ctl_s[0]),
    .haddr       (hst_addr),
    .hwdata      (hst_wdata),
    .bus16       (cfg_bus16),
    .card8       (card_8bit),
    .hrdata      (hst_rdata),
    .wait_act    (wait_act),
    .isa_addr    (isa_addr),
    .isa_dout    (isa_dout),
    .isa_dout_en (isa_dout_en),
    .isa_din     (isa_din),
    .isa_rdy     (isa_rdy),
    .memr_n      (isa_memr_n),
    .memw_n      (isa_memw_n),
    .ior_n       (isa_ior_n),
    .iow_n       (isa_iow_n)
  );

  assign hst_wait_n   = !wait_act;
  assign hst_rdata_en = !hst_cs_n && !hst_oe_n;

  a_r10_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n_s)
    !seq_ready |-> (hst_wait_n && isa_memr_n && isa_memw_n && isa_ior_n && isa_iow_n));

endmodule

// File: tb/sim_smc_isa_bridge.sv
module sim_smc_isa_bridge;

  localparam int STB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_cs_n = 1'b1, hst_oe_n = 1'b1, hst_we_n = 1'b1;
  logic [24:0] hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        hst_rdata_en, hst_wait_n;
  logic        cfg_bus16 = 1'b1, card_8bit = 1'b0;
  logic        sock_rst;
  logic [23:0] isa_addr;
  logic [15:0] isa_dout, isa_din;
  logic        isa_dout_en;
  logic        isa_rdy = 1'b1;
  logic        isa_memr_n, isa_memw_n, isa_ior_n, isa_iow_n;

  always #2 clk = ~clk;

  smc_isa_bridge u0 (
    .clk(clk), .rst_n(rst_n), .hst_cs_n(hst_cs_n), .hst_oe_n(hst_oe_n),
    .hst_we_n(hst_we_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_rdata_en(hst_rdata_en), .hst_wait_n(hst_wait_n),
    .cfg_bus16(cfg_bus16), .card_8bit(card_8bit), .sock_rst(sock_rst),
    .isa_addr(isa_addr), .isa_dout(isa_dout), .isa_dout_en(isa_dout_en),
    .isa_din(isa_din), .isa_rdy(isa_rdy), .isa_memr_n(isa_memr_n),
    .isa_memw_n(isa_memw_n), .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n)
  );

  function automatic logic [7:0] card_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign isa_din = {card_byte(isa_addr | 24'h1), card_byte(isa_addr)};

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 memr, 1 memw, 2 ior, 3 iow
    logic [23:0] addr;
    logic [15:0] data;
    logic        bytew;
    logic [7:0]  dly;
  } exp_t;

  exp_t exp_q[$];

  // monitor / card model
  bit   prev_any = 1'b0;
  int   cur_len  = 0;
  int   rdy_cnt  = 0;
  exp_t cur;

  always @(negedge clk) begin
    logic [3:0] stb;
    int kind;
    int exp_len;
    stb = ~{isa_iow_n, isa_ior_n, isa_memw_n, isa_memr_n};
    if ($countones(stb) > 1) chk(1'b0, "R4", "several strobes", int'(stb), 0);
    kind = 0;
    for (int i = 0; i < 4; i++) if (stb[i]) kind = i;
    if ((|stb) && !prev_any) begin
      cur_len = 1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected strobe", int'(stb), 0);
        cur = '0;
      end else begin
        cur = exp_q.pop_front();
        chk(kind == int'(cur.kind), "R4", "strobe kind", kind, int'(cur.kind));
        chk(isa_addr == cur.addr, "R3", "isa address", int'(isa_addr), int'(cur.addr));
        if (cur.kind[0]) begin
          chk(isa_dout_en, "R8", "write data enable", int'(isa_dout_en), 1);
          if (cur.bytew)
            chk(isa_dout == {8'h00, cur.data[7:0]}, "R7", "byte write data",
                int'(isa_dout), int'(cur.data[7:0]));
          else
            chk(isa_dout == cur.data, "R8", "word write data",
                int'(isa_dout), int'(cur.data));
        end
        if (cur.dly != 0) begin
          isa_rdy = 1'b0;
          rdy_cnt = int'(cur.dly);
        end
      end
    end else if (|stb) begin
      cur_len++;
      if (rdy_cnt > 0) begin
        rdy_cnt--;
        if (rdy_cnt == 0) isa_rdy = 1'b1;
      end
    end else if (prev_any) begin
      exp_len = (int'(cur.dly) + 1 > STB + 1) ? int'(cur.dly) + 1 : STB + 1;
      chk(cur_len == exp_len, "R5", "strobe length", cur_len, exp_len);
    end
    prev_any = |stb;
  end

  task automatic host_access(input bit wr, input bit io, input logic [23:0] a,
                             input logic [15:0] wd, input bit b16, input bit c8,
                             input int dly);
    bit   split;
    exp_t e;
    int   n;
    int   mn;
    logic [15:0] exp_rd;
    split = b16 && c8;
    mn = split ? (io ? 22 : 24) : (io ? 9 : 10);
    e.kind = {io, wr};
    e.dly  = 8'(dly);
    if (split) begin
      e.bytew = 1'b1;
      e.addr = {a[23:1], 1'b0}; e.data = {8'h00, wd[7:0]};  exp_q.push_back(e);
      e.addr = {a[23:1], 1'b1}; e.data = {8'h00, wd[15:8]}; exp_q.push_back(e);
    end else begin
      e.bytew = 1'b0;
      e.addr = a; e.data = wd; exp_q.push_back(e);
    end
    exp_rd = {card_byte(a | 24'h1), card_byte({a[23:1], 1'b0})};
    @(negedge clk);
    cfg_bus16 = b16; card_8bit = c8;
    hst_addr = {io, a}; hst_wdata = wd;
    hst_cs_n = 1'b0;
    if (wr) hst_we_n = 1'b0; else hst_oe_n = 1'b0;
    @(negedge clk);
    chk(hst_wait_n == 1'b1, "R2", "wait before one clock", int'(hst_wait_n), 1);
    @(negedge clk);
    chk(hst_wait_n == 1'b0, "R2", "wait within two clocks", int'(hst_wait_n), 0);
    n = 0;
    while (hst_wait_n == 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
    chk(n >= mn, "R6", "wait length", n, mn);
    if (dly > 0) chk(n > dly, "R5", "wait covers ready delay", n, dly + 1);
    chk(isa_memr_n && isa_memw_n && isa_ior_n && isa_iow_n, "R9",
        "strobe ended before wait release", 0, 0);
    chk(exp_q.size() == 0, split ? "R7" : "R8", "ISA cycles issued",
        exp_q.size(), 0);
    if (!wr) begin
      chk(hst_rdata == exp_rd, split ? "R7" : "R8", "read word",
          int'(hst_rdata), int'(exp_rd));
      chk(hst_rdata_en == 1'b1, "R9", "read drive enable", int'(hst_rdata_en), 1);
    end
    hst_cs_n = 1'b1; hst_oe_n = 1'b1; hst_we_n = 1'b1;
    #1;
    chk(hst_rdata_en == 1'b0, "R9", "drive enable off", int'(hst_rdata_en), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sock_rst == 1'b1, "R1", "socket reset in reset", int'(sock_rst), 1);
    chk(hst_wait_n == 1'b1, "R1", "wait in reset", int'(hst_wait_n), 1);
    chk(isa_memr_n && isa_memw_n && isa_ior_n && isa_iow_n, "R1",
        "strobes in reset", 0, 0);
    rst_n = 1'b1;
    n = 0;
    while (sock_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n >= 13, "R10", "socket reset hold", n, 13);
    // R10 guard window: access ignored
    hst_addr = 25'h0000100; hst_wdata = 16'h1111;
    hst_cs_n = 1'b0; hst_we_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(hst_wait_n == 1'b1, "R10", "no wait in guard", int'(hst_wait_n), 1);
    end
    hst_cs_n = 1'b1; hst_we_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(isa_memw_n == 1'b1, "R10", "no strobe from guard access", int'(isa_memw_n), 1);

    host_access(1'b1, 1'b0, 24'h001234, 16'hC0DE, 1'b1, 1'b0, 0); // R8 mem write
    host_access(1'b1, 1'b1, 24'h0003F0, 16'hA55A, 1'b1, 1'b0, 0); // R3 io write
    host_access(1'b0, 1'b0, 24'h00ABC0, 16'h0000, 1'b1, 1'b0, 0); // R8 mem read
    host_access(1'b0, 1'b1, 24'h000170, 16'h0000, 1'b1, 1'b0, 9); // R5 io read, ready delay
    host_access(1'b1, 1'b0, 24'h000200, 16'hBEEF, 1'b1, 1'b1, 0); // R7 split mem write
    host_access(1'b0, 1'b1, 24'h0001F0, 16'h0000, 1'b1, 1'b1, 7); // R7 split io read
    host_access(1'b0, 1'b0, 24'h345670, 16'h0000, 1'b1, 1'b1, 0); // R7 split mem read
    host_access(1'b1, 1'b1, 24'h000388, 16'h7E81, 1'b1, 1'b1, 3); // R7 split io write
    host_access(1'b1, 1'b0, 24'h000400, 16'h0042, 1'b0, 1'b1, 0); // R7 no split, 8-bit host
    host_access(1'b0, 1'b1, 24'h0002E0, 16'h0000, 1'b1, 1'b0, 20); // R5 long ready delay

    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule